// File: doc/BRIEF.md
# Continuous-Phase Two-Tone Square-Wave Modulator

This block turns a transmit bit stream into a frequency-shifted square-wave carrier. A 12-bit phase accumulator runs on a clock that is a fixed multiple of a reference crystal. On every clock it adds one of two increments: the mark step when the data bit is one and the space step when it is zero. The accumulator's top bit is the carrier. When the data changes, only the step size changes and the accumulated phase is kept, so the output frequency moves between the two tones without a phase jump. The deviation is 13·N·Fref/4096. With N = 18 and a 32.768 kHz reference this gives about 1872 Hz around a nominal carrier near 36.86 kHz. The choice between the two carrier frequencies is made by the clock rate that feeds the block and is not a logic input.

The data bit is taken as presented, through a single register stage. There is no oversampling, filtering or bit timing, so the block accepts any data rate. A 3-bit power code selects one of six drive strengths for an external power amplifier. The strength is presented as a one-hot select bus. The two highest codes are reserved: they turn every select line off and raise an error flag. When transmit is disabled, the accumulator clears, the carrier output is held low and every amplifier select line is off.

Top module: `cpfsk_tx_mod`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `carrier_out`, `amp_sel` and `pwr_err` are all 0, and the phase accumulator holds 0.
- R2: While `tx_en` is high, each clock adds 269 to the accumulator when the registered data bit is 1 and 243 when it is 0. From a cleared accumulator with the data bit held at 1, `carrier_out` first goes high after the 8th enabled clock. With the data bit held at 0 it first goes high after the 9th.
- R3: The accumulator is 12 bits wide and wraps modulo 4096. `carrier_out` equals its bit 11 while `tx_en` is high.
- R4: `tx_bit` passes through exactly one register. A change on `tx_bit` alters the increment used on the second clock edge after the change, not the first.
- R5: A change of the data bit never alters the accumulator contents. Only the increment changes, so the phase stays continuous.
- R6: When `tx_en` is low, `carrier_out` is 0 in the same cycle, and the accumulator is 0 after the next clock edge.
- R7: For a power code k from 0 to 5 with `tx_en` high, `amp_sel` is one-hot with only bit k set (bit 0 is the weakest drive, bit 5 the strongest) on the clock after the code is presented.
- R8: Power codes 6 and 7 are reserved. One clock after such a code is presented, `amp_sel` is all zeros and `pwr_err` is 1. For codes 0 to 5, `pwr_err` is 0.
- R9: When `tx_en` is low, `amp_sel` is all zeros one clock later, whatever the power code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock from the frequency multiplier |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| tx_bit | input | 1 | Real-time data bit |
| pwr_code | input | 3 | Drive strength code, 0 weakest to 5 strongest, 6 and 7 reserved |
| carrier_out | output | 1 | Modulated square-wave carrier (accumulator MSB) |
| amp_sel | output | 6 | One-hot drive strength select for the power amplifier |
| pwr_err | output | 1 | High when the last presented power code was reserved |

## Verification
The bench first measures how many enabled clocks each tone needs before the carrier first rises. Swapped or wrong increments would shift that count away from 8 or 9. It then toggles the data bit in the middle of a run while tracking phase with its own model. A design that reloaded or cleared the phase on a data change, or that skipped or doubled the data register, would drift from that model within a few cycles. Disable and re-enable tests catch a carrier left high or a phase left over from the last burst. Sweeps of every power code, including both reserved ones, catch a select line that stays on or an error flag that is missing.

// File: rtl/cpfsk_pkg.sv
package cpfsk_pkg;
    localparam int PHASE_W    = 12;
    localparam int CENTER_INC = 256;
    localparam int DEV_INC    = 13;
    localparam int CODE_W     = 3;
    localparam int NUM_LEVELS = 6;

    typedef enum logic [CODE_W-1:0] {
        LVL_MIN  = 3'd0,
        LVL_LOW  = 3'd1,
        LVL_MID  = 3'd2,
        LVL_HIGH = 3'd3,
        LVL_XHI  = 3'd4,
        LVL_MAX  = 3'd5,
        LVL_RSV0 = 3'd6,
        LVL_RSV1 = 3'd7
    } pwr_level_e;

    typedef struct packed {
        logic [NUM_LEVELS-1:0] sel;
        logic                  err;
    } amp_ctrl_t;

    function automatic logic code_reserved(input logic [CODE_W-1:0] code);
        return code >= CODE_W'(NUM_LEVELS);
    endfunction

    function automatic logic [PHASE_W-1:0] tone_step(input logic mark,
                                                     input int center,
                                                     input int dev);
        return mark ? PHASE_W'(center + dev) : PHASE_W'(center - dev);
    endfunction
endpackage

// File: rtl/cpfsk_bit_reg.sv
module cpfsk_bit_reg (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_q
);
    always_ff @(posedge clk) begin
        if (rst) d_q <= 1'b0;
        else     d_q <= d_in;
    end
endmodule

// File: rtl/cpfsk_phase_acc.sv
module cpfsk_phase_acc #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [WIDTH-1:0] step,
    output logic [WIDTH-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else             phase <= phase + step;
    end
endmodule

// File: rtl/cpfsk_amp_decode.sv
module cpfsk_amp_decode
    import cpfsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [CODE_W-1:0] code,
    output amp_ctrl_t         ctrl
);
    amp_ctrl_t nxt;

    always_comb begin
        nxt.err = code_reserved(code);
    end

    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_lvl
        always_comb nxt.sel[k] = enable && (code == CODE_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else     ctrl <= nxt;
    end
endmodule

// File: rtl/cpfsk_tx_mod.sv
module cpfsk_tx_mod
    import cpfsk_pkg::*;
#(
    parameter int ACC_W  = PHASE_W,
    parameter int CENTER = CENTER_INC,
    parameter int DEV    = DEV_INC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tx_en,
    input  logic                  tx_bit,
    input  logic [CODE_W-1:0]     pwr_code,
    output logic                  carrier_out,
    output logic [NUM_LEVELS-1:0] amp_sel,
    output logic                  pwr_err
);
    logic             bit_q;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] phase;
    amp_ctrl_t        amp;

    cpfsk_bit_reg u_bit (
        .clk  (clk),
        .rst  (rst),
        .d_in (tx_bit),
        .d_q  (bit_q)
    );

    assign step = bit_q ? ACC_W'(CENTER + DEV) : ACC_W'(CENTER - DEV);

    cpfsk_phase_acc #(.WIDTH(ACC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .run   (tx_en),
        .step  (step),
        .phase (phase)
    );

    cpfsk_amp_decode u_amp (
        .clk    (clk),
        .rst    (rst),
        .enable (tx_en),
        .code   (pwr_code),
        .ctrl   (amp)
    );

    assign carrier_out = tx_en && phase[ACC_W-1];
    assign amp_sel     = amp.sel;
    assign pwr_err     = amp.err;
endmodule

// File: rtl/cpfsk_tx_chk.sv
module cpfsk_tx_chk
    import cpfsk_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  tx_en,
    input logic                  tx_bit,
    input logic [CODE_W-1:0]     pwr_code,
    input logic                  carrier_out,
    input logic [NUM_LEVELS-1:0] amp_sel,
    input logic                  pwr_err,
    input logic                  bit_q,
    input logic [PHASE_W-1:0]    phase
);
    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> (phase == '0 && amp_sel == '0 && !pwr_err));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        tx_en |=> phase == PHASE_W'($past(phase) + ($past(bit_q) ? 12'd269 : 12'd243)));

    p_msb_r3: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> carrier_out == phase[PHASE_W-1]);

    p_bit_delay_r4: assert property (@(posedge clk)
        !rst |=> bit_q == $past(tx_bit));

    p_low_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !carrier_out);

    p_clear_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> phase == '0);

    p_onehot_r7: assert property (@(posedge clk) $onehot0(amp_sel));

    p_level_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_en && pwr_code < 3'd6) |=> amp_sel == NUM_LEVELS'(1 << $past(pwr_code)));

    p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (pwr_code >= 3'd6) |=> (amp_sel == '0 && pwr_err));

    p_off_amp_r9: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> amp_sel == '0);
endmodule

bind cpfsk_tx_mod cpfsk_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (tx_en),
    .tx_bit      (tx_bit),
    .pwr_code    (pwr_code),
    .carrier_out (carrier_out),
    .amp_sel     (amp_sel),
    .pwr_err     (pwr_err),
    .bit_q       (bit_q),
    .phase       (phase)
);

// File: tb/sim_cpfsk_tx_mod.sv
`timescale 1ns/1ps
module sim_cpfsk_tx_mod;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       tx_bit = 1'b0;
    logic [2:0] pwr_code = 3'd0;
    logic       carrier_out;
    logic [5:0] amp_sel;
    logic       pwr_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [11:0] m_acc = '0;
    logic        m_bitq = 1'b0;
    logic [5:0]  m_sel = '0;
    logic        m_err = 1'b0;

    always #2 clk = ~clk;

    cpfsk_tx_mod u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_bit(tx_bit),
        .pwr_code(pwr_code), .carrier_out(carrier_out),
        .amp_sel(amp_sel), .pwr_err(pwr_err)
    );

    function automatic logic [5:0] exp_sel(input logic en, input logic [2:0] c);
        return (en && c < 3'd6) ? 6'(1 << c) : 6'd0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: model advances with the inputs seen at the edge, then outputs are compared
    task automatic step(input string req);
        @(posedge clk);
        if (rst) begin
            m_acc = '0; m_bitq = 1'b0; m_sel = '0; m_err = 1'b0;
        end else begin
            m_acc  = tx_en ? 12'(m_acc + (m_bitq ? 12'd269 : 12'd243)) : 12'd0;
            m_bitq = tx_bit;
            m_sel  = exp_sel(tx_en, pwr_code);
            m_err  = (pwr_code >= 3'd6);
        end
        #1;
        chk({req, " carrier"}, int'(carrier_out), int'(tx_en && m_acc[11]));
        chk({req, " amp_sel"}, int'(amp_sel), int'(m_sel));
        chk({req, " pwr_err"}, int'(pwr_err), int'(m_err));
        @(negedge clk);
    endtask

    task automatic count_rise(input logic b, input int exp_n, input string req);
        int n;
        tx_en = 1'b0; tx_bit = b;
        step("R6 prime");
        step("R6 prime");
        tx_en = 1'b1;
        n = 0;
        while (!carrier_out && n < 40) begin
            step(req);
            n++;
        end
        chk({req, " edges to first rise"}, n, exp_n);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1209);
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        rst = 1'b0;
        step("R1 after reset");

        // R2 tone periods from a cleared accumulator
        count_rise(1'b1, 8, "R2 mark");
        count_rise(1'b0, 9, "R2 space");

        // R3 wrap: long mark run
        tx_en = 1'b1; tx_bit = 1'b1;
        for (int i = 0; i < 60; i++) step("R3 wrap");

        // R4/R5 data toggles mid-run, phase carried through
        for (int i = 0; i < 80; i++) begin
            tx_bit = (i % 3 == 0) ? ~tx_bit : tx_bit;
            step("R4 R5 toggle");
        end

        // R6 disable, then re-enable from zero
        tx_en = 1'b0;
        chk("R6 same-cycle low", int'(carrier_out), 0);
        step("R6 off");
        step("R6 off");
        tx_en = 1'b1;
        for (int i = 0; i < 10; i++) step("R6 restart");

        // R7/R8/R9 sweep every code enabled and disabled
        for (int c = 0; c < 8; c++) begin
            pwr_code = 3'(c);
            tx_en = 1'b1;
            step("R7 R8 code");
            tx_en = 1'b0;
            step("R9 code off");
        end

        // random mix
        for (int i = 0; i < 4000; i++) begin
            tx_bit   = 1'($urandom);
            pwr_code = 3'($urandom);
            tx_en    = ($urandom % 16) != 0;
            rst      = ($urandom % 500) == 0;
            step("R2 R3 R5 random");
        end
        rst = 1'b1;
        step("R1 final reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule